// File: doc/BRIEF.md
# Privilege-Aware Branch Target Buffer

This block predicts where an indirect branch or a return will go. On the lookup side it takes a fetch address and the privilege level of the code being fetched. One cycle later it reports a hit, the predicted target and a taken hint. On the update side it takes resolved branches: the branch address, its target, the taken outcome, the privilege level of the code that executed it, and a flag saying whether that branch faulted. A new entry is created, or an existing entry is refreshed in place.

The table is set-associative. A fixed slice of the branch address picks the set. Each way keeps only a short partial tag, so unrelated branches whose low address bits agree share one entry. Each entry also records the privilege level that trained it. When the restriction input is high, entries trained at a lower level than the requester are invisible to that lookup. A barrier input wipes every entry in a single cycle.

Top module: `btb_core`

## Requirements
- R1: The set is selected by address bits [11:6], which gives 64 sets. Bits [5:0] play no part in set selection or tag matching, and a branch lives only in its own set.
- R2: Each set holds 4 ways. Four branches with distinct partial tags in one set are all retained, each with its own target.
- R3: The partial tag is address bits [15:12]. A lookup whose bits [15:0] equal those of a trained branch hits and returns that branch's target, whatever bits [31:16] hold.
- R4: Lookup results are registered and appear in the cycle after `lk_valid`. When a lookup misses, or when no lookup was issued, `pr_hit`, `pr_target` and `pr_taken` are all 0.
- R5: An update issued in the same cycle as a lookup to the same entry is not seen by that lookup. It is seen by every later lookup.
- R6: An update whose set and partial tag match a valid entry rewrites that entry's target, taken hint and owner level in place. The set's victim pointer does not move.
- R7: An update that matches no valid entry writes the way chosen by its set's round-robin victim pointer, then advances that pointer by one. When a full set receives a fifth new tag, the oldest allocation is evicted, even if that entry was refreshed since it was allocated.
- R8: The fault flag has no effect. A faulting update is written exactly as a clean one.
- R9: Pulsing `barrier` for one cycle invalidates every entry. Every lookup issued after that cycle misses until new training arrives.
- R10: When `barrier` and an update arrive in the same cycle, the barrier wins and the table is left empty.
- R11: Privilege levels are encoded 0 (least privileged) to 3 (most privileged). When `restrict_en` is 1 during a lookup, an entry whose owner level is lower than `lk_priv` does not hit. When `restrict_en` is 0, owner level is ignored.
- R12: On a hit, `pr_taken` equals the taken flag of the most recent update written to that entry.
- R13: While `rst` is high, and in the first cycle after it, all outputs are 0 and the table holds no valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | Fetch address to predict |
| lk_priv | input | 2 | Privilege level of the lookup (0 lowest, 3 highest) |
| restrict_en | input | 1 | Hide entries trained at a lower level than the lookup |
| pr_hit | output | 1 | Registered: previous lookup found a visible entry |
| pr_target | output | 32 | Registered: predicted target, 0 on a miss |
| pr_taken | output | 1 | Registered: stored taken hint, 0 on a miss |
| up_valid | input | 1 | Resolved branch report this cycle |
| up_pc | input | 32 | Address of the resolved branch |
| up_target | input | 32 | Resolved target |
| up_taken | input | 1 | Resolved taken outcome |
| up_priv | input | 2 | Privilege level of the code that ran the branch |
| up_fault | input | 1 | Branch faulted (training still happens) |
| barrier | input | 1 | Invalidate every entry |

## Verification
All 64 sets are trained with targets and hints computed from the set number. Each set is then probed twice: once with scrambled offset bits, which must still hit, and once with a neighbouring tag, which must miss. This separates correct set and tag slicing from mixed-up bit fields. Aliasing is exercised by sweeping the upper address half while keeping the low 16 bits fixed. A sequence of five and then six tags driven into one set tells round-robin replacement apart from replacement that follows recency or refreshes. A full cross of owner level, requester level and the restriction bit, together with same-cycle lookup/update and barrier/update collisions, covers the privilege filter and the ordering rules.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int PRIV_W = 2;

    typedef enum logic [PRIV_W-1:0] {
        PL_USER     = 2'd0,
        PL_KERNEL   = 2'd1,
        PL_HYPER    = 2'd2,
        PL_FIRMWARE = 2'd3
    } priv_t;

    typedef enum logic {
        UPD_CLEAN   = 1'b0,
        UPD_FAULTED = 1'b1
    } upd_kind_t;

    typedef struct packed {
        logic  valid;
        logic  taken;
        priv_t owner;
    } meta_t;

    // Training policy: faulting branches train the table like clean ones.
    function automatic logic kind_trains(upd_kind_t k);
        case (k)
            UPD_CLEAN:   return 1'b1;
            UPD_FAULTED: return 1'b1;
            default:     return 1'b1;
        endcase
    endfunction

    // An entry is visible unless restriction is on and its trainer ranks below the requester.
    function automatic logic owner_visible(logic restrict_on, priv_t owner, priv_t req);
        return !restrict_on || (owner >= req);
    endfunction

endpackage

// File: rtl/btb_pc_split.sv
module btb_pc_split #(
    parameter int PC_W   = 32,
    parameter int IDX_LO = 6,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 4
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] set_idx,
    output logic [TAG_W-1:0] ptag
);
    localparam int TAG_LO = IDX_LO + IDX_W;
    localparam int TAG_HI = TAG_LO + TAG_W - 1;

    assign set_idx = pc[TAG_LO-1:IDX_LO];
    assign ptag    = pc[TAG_HI:TAG_LO];

    // Offset and high bits are deliberately dropped (aliasing by design).
    logic pc_unused;
    assign pc_unused = ^{pc[IDX_LO-1:0], pc[PC_W-1:TAG_HI+1]};
endmodule

// File: rtl/btb_table.sv
module btb_table
    import btb_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int TAG_W = 4,
    parameter int TGT_W = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          wr_en,
    input  logic [SET_W-1:0]              wr_set,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic [TGT_W-1:0]              wr_tgt,
    input  meta_t                         wr_meta,
    input  logic [SET_W-1:0]              rda_set,
    output logic [WAYS-1:0][TAG_W-1:0]    rda_tag,
    output logic [WAYS-1:0][TGT_W-1:0]    rda_tgt,
    output meta_t [WAYS-1:0]              rda_meta,
    input  logic [SET_W-1:0]              rdb_set,
    output logic [WAYS-1:0][TAG_W-1:0]    rdb_tag,
    output meta_t [WAYS-1:0]              rdb_meta,
    output logic [SETS*WAYS-1:0]          vld_flat
);
    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    logic [TGT_W-1:0] tgt_q  [SETS][WAYS];
    meta_t            meta_q [SETS][WAYS];

    // Metadata: reset and flush clear all, flush beats a write.
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    meta_q[s][w] <= '0;
                end
            end
        end else if (wr_en) begin
            meta_q[wr_set][wr_way] <= wr_meta;
        end
    end

    // Payload needs no reset: it is only seen through a valid entry.
    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag_q[wr_set][wr_way] <= wr_tag;
            tgt_q[wr_set][wr_way] <= wr_tgt;
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rda_tag[w]  = tag_q[rda_set][w];
            rda_tgt[w]  = tgt_q[rda_set][w];
            rda_meta[w] = meta_q[rda_set][w];
            rdb_tag[w]  = tag_q[rdb_set][w];
            rdb_meta[w] = meta_q[rdb_set][w];
        end
    end

    for (genvar s = 0; s < SETS; s++) begin : g_vs
        for (genvar w = 0; w < WAYS; w++) begin : g_vw
            assign vld_flat[s*WAYS + w] = meta_q[s][w].valid;
        end
    end
endmodule

// File: rtl/btb_way_match.sv
module btb_way_match
    import btb_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int TAG_W = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  meta_t [WAYS-1:0]           metas,
    input  logic [TAG_W-1:0]           q_tag,
    input  priv_t                      q_priv,
    input  logic                       restrict_on,
    output logic                       hit,
    output logic [WAY_W-1:0]           way
);
    logic [WAYS-1:0] cand;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign cand[w] = metas[w].valid
                      && (tags[w] == q_tag)
                      && owner_visible(restrict_on, metas[w].owner, q_priv);
    end

    always_comb begin
        hit = |cand;
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (cand[w]) way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/btb_victim_rr.sv
module btb_victim_rr #(
    parameter int SETS = 64,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_en,
    input  logic [SET_W-1:0] q_set,
    output logic [WAY_W-1:0] victim
);
    logic [WAY_W-1:0] ptr_q [SETS];

    assign victim = ptr_q[q_set];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (adv_en) begin
            if (ptr_q[q_set] == WAY_W'(WAYS - 1)) ptr_q[q_set] <= '0;
            else                                  ptr_q[q_set] <= ptr_q[q_set] + 1'b1;
        end
    end
endmodule

// File: rtl/btb_core.sv
module btb_core
    import btb_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_LO = 6,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 4,
    parameter int WAYS   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic [PRIV_W-1:0] lk_priv,
    input  logic              restrict_en,
    output logic              pr_hit,
    output logic [PC_W-1:0]   pr_target,
    output logic              pr_taken,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic [PC_W-1:0]   up_target,
    input  logic              up_taken,
    input  logic [PRIV_W-1:0] up_priv,
    input  logic              up_fault,
    input  logic              barrier
);
    localparam int SETS  = 1 << IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    logic [IDX_W-1:0] lk_set, up_set;
    logic [TAG_W-1:0] lk_tag, up_tag;

    btb_pc_split #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W), .TAG_W(TAG_W)) lk_split_i (
        .pc(lk_pc), .set_idx(lk_set), .ptag(lk_tag)
    );
    btb_pc_split #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W), .TAG_W(TAG_W)) up_split_i (
        .pc(up_pc), .set_idx(up_set), .ptag(up_tag)
    );

    logic [WAYS-1:0][TAG_W-1:0] lk_tags, up_tags;
    logic [WAYS-1:0][PC_W-1:0]  lk_tgts;
    meta_t [WAYS-1:0]           lk_metas, up_metas;
    logic [SETS*WAYS-1:0]       vld_flat;

    logic             wr_en, up_hit, lk_hit, alloc;
    logic [WAY_W-1:0] up_way, lk_way, victim, wr_way;
    meta_t            wr_meta;

    btb_table #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .TGT_W(PC_W)) table_i (
        .clk(clk), .rst(rst), .flush(barrier),
        .wr_en(wr_en), .wr_set(up_set), .wr_way(wr_way), .wr_tag(up_tag),
        .wr_tgt(up_target), .wr_meta(wr_meta),
        .rda_set(lk_set), .rda_tag(lk_tags), .rda_tgt(lk_tgts), .rda_meta(lk_metas),
        .rdb_set(up_set), .rdb_tag(up_tags), .rdb_meta(up_metas),
        .vld_flat(vld_flat)
    );

    // Lookup side applies the privilege filter.
    btb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) lk_match_i (
        .tags(lk_tags), .metas(lk_metas), .q_tag(lk_tag),
        .q_priv(priv_t'(lk_priv)), .restrict_on(restrict_en),
        .hit(lk_hit), .way(lk_way)
    );

    // Update side finds an existing entry regardless of its owner.
    btb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) up_match_i (
        .tags(up_tags), .metas(up_metas), .q_tag(up_tag),
        .q_priv(priv_t'(up_priv)), .restrict_on(1'b0),
        .hit(up_hit), .way(up_way)
    );

    btb_victim_rr #(.SETS(SETS), .WAYS(WAYS)) victim_i (
        .clk(clk), .rst(rst), .adv_en(alloc), .q_set(up_set), .victim(victim)
    );

    always_comb begin
        wr_en         = up_valid && kind_trains(upd_kind_t'(up_fault));
        wr_way        = up_hit ? up_way : victim;
        alloc         = wr_en && !up_hit && !barrier;
        wr_meta.valid = 1'b1;
        wr_meta.taken = up_taken;
        wr_meta.owner = priv_t'(up_priv);
    end

    logic            lk_found;
    logic [PC_W-1:0] sel_tgt;
    meta_t           sel_meta;

    assign lk_found = lk_valid && lk_hit;
    assign sel_tgt  = lk_tgts[lk_way];
    assign sel_meta = lk_metas[lk_way];

    always_ff @(posedge clk) begin
        if (rst) begin
            pr_hit    <= 1'b0;
            pr_target <= '0;
            pr_taken  <= 1'b0;
        end else begin
            pr_hit    <= lk_found;
            pr_target <= lk_found ? sel_tgt : '0;
            pr_taken  <= lk_found && sel_meta.taken;
        end
    end
endmodule

// File: rtl/btb_core_chk.sv
module btb_core_chk #(
    parameter int PC_W  = 32,
    parameter int SLOTS = 256
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             up_valid,
    input logic             barrier,
    input logic             pr_hit,
    input logic [PC_W-1:0]  pr_target,
    input logic             pr_taken,
    input logic [SLOTS-1:0] vld_flat
);
    AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        pr_hit |-> $past(lk_valid)); // R4

    AST_MISS_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !pr_hit |-> (pr_target == '0 && !pr_taken)); // R4

    AST_BARRIER_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        barrier |=> (vld_flat == '0)); // R9

    AST_BARRIER_BEATS_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (barrier && up_valid) |=> (vld_flat == '0)); // R10

    AST_BARRIER_THEN_MISS: assert property (@(posedge clk) disable iff (rst)
        barrier |-> ##2 !pr_hit); // R9

    AST_ONE_ALLOC_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
        $countones(vld_flat) <= $countones($past(vld_flat)) + 1); // R7
endmodule

bind btb_core btb_core_chk #(.PC_W(PC_W), .SLOTS(SETS*WAYS)) chk_i (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .up_valid(up_valid),
    .barrier(barrier), .pr_hit(pr_hit), .pr_target(pr_target),
    .pr_taken(pr_taken), .vld_flat(vld_flat)
);

// File: tb/btb_core_tb.sv
module btb_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic [1:0]  lk_priv = '0;
    logic        restrict_en = 1'b0;
    logic        pr_hit;
    logic [31:0] pr_target;
    logic        pr_taken;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic [31:0] up_target = '0;
    logic        up_taken = 1'b0;
    logic [1:0]  up_priv = '0;
    logic        up_fault = 1'b0;
    logic        barrier = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic        r_hit;
    logic [31:0] r_tgt;
    logic        r_taken;

    always #2 clk = ~clk; // 250 MHz

    btb_core dut_i (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_priv(lk_priv),
        .restrict_en(restrict_en), .pr_hit(pr_hit), .pr_target(pr_target),
        .pr_taken(pr_taken), .up_valid(up_valid), .up_pc(up_pc),
        .up_target(up_target), .up_taken(up_taken), .up_priv(up_priv),
        .up_fault(up_fault), .barrier(barrier)
    );

    function automatic logic [31:0] mkpc(input logic [15:0] hi, input logic [3:0] tg,
                                         input logic [5:0] st, input logic [5:0] off);
        return {hi, tg, st, off};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic train(input logic [31:0] pc, input logic [31:0] tgt, input logic tk,
                         input logic [1:0] pv, input logic flt);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_target = tgt; up_taken = tk;
        up_priv = pv; up_fault = flt;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic look(input logic [31:0] pc, input logic [1:0] pv, input logic rs);
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = pc; lk_priv = pv; restrict_en = rs;
        @(negedge clk);
        lk_valid = 1'b0; restrict_en = 1'b0;
        r_hit = pr_hit; r_tgt = pr_target; r_taken = pr_taken;
    endtask

    task automatic wipe();
        @(negedge clk);
        barrier = 1'b1;
        @(negedge clk);
        barrier = 1'b0;
    endtask

    // Expect a hit with a given target and hint.
    task automatic expect_hit(input string req, input logic [31:0] tgt, input logic tk);
        chk(req, {31'b0, r_hit}, 32'd1);
        chk(req, r_tgt, tgt);
        chk(req, {31'b0, r_taken}, {31'b0, tk});
    endtask

    task automatic expect_miss(input string req);
        chk(req, {r_taken, r_hit, 30'b0} | r_tgt, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R13: reset state
        repeat (3) @(negedge clk);
        chk("R13 reset outputs", {pr_taken, pr_hit, 30'b0} | pr_target, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R13 after reset", {pr_taken, pr_hit, 30'b0} | pr_target, 32'd0);
        look(mkpc(16'h0, 4'h0, 6'd0, 6'd0), 2'd0, 1'b0);
        expect_miss("R13 empty table");

        // R1 R3 R8 R12: one entry per set, offset bits scrambled on lookup
        for (int s = 0; s < 64; s++) begin
            train(mkpc(16'h1234, 4'(s), 6'(s), 6'd0), 32'h4000_0000 + 32'(s * 4),
                  s[0], 2'd0, s[1]);
        end
        for (int s = 0; s < 64; s++) begin
            look(mkpc(16'h1234, 4'(s), 6'(s), 6'(63 - s)), 2'd0, 1'b0);
            expect_hit("R1 R8 R12 set sweep", 32'h4000_0000 + 32'(s * 4), s[0]);
            look(mkpc(16'h1234, 4'(s + 1), 6'(s), 6'd0), 2'd0, 1'b0);
            expect_miss("R3 R1 neighbour tag misses");
        end

        // R3: aliasing across the upper half of the address
        for (int h = 0; h < 16; h++) begin
            look(mkpc(16'(h * 16'h1111), 4'd9, 6'd9, 6'd0), 2'd3, 1'b0);
            expect_hit("R3 alias upper bits", 32'h4000_0000 + 32'd36, 1'b1);
        end

        // R9: barrier wipes every set
        wipe();
        for (int s = 0; s < 64; s++) begin
            look(mkpc(16'h1234, 4'(s), 6'(s), 6'd0), 2'd0, 1'b0);
            expect_miss("R9 after barrier");
        end

        // R2 R6 R7: fill one set, evict round robin
        for (int t = 1; t <= 4; t++) train(mkpc(16'h0, 4'(t), 6'd5, 6'd0), 32'h5000_0000 + 32'(t), 1'b1, 2'd1, 1'b0);
        for (int t = 1; t <= 4; t++) begin
            look(mkpc(16'h0, 4'(t), 6'd5, 6'd0), 2'd1, 1'b0);
            expect_hit("R2 four ways held", 32'h5000_0000 + 32'(t), 1'b1);
        end
        train(mkpc(16'h0, 4'd5, 6'd5, 6'd0), 32'h5000_0005, 1'b0, 2'd1, 1'b0);
        look(mkpc(16'h0, 4'd1, 6'd5, 6'd0), 2'd1, 1'b0);
        expect_miss("R7 oldest evicted");
        for (int t = 2; t <= 5; t++) begin
            look(mkpc(16'h0, 4'(t), 6'd5, 6'd0), 2'd1, 1'b0);
            expect_hit("R7 survivors", 32'h5000_0000 + 32'(t), t != 5);
        end
        train(mkpc(16'h0, 4'd2, 6'd5, 6'd0), 32'h6000_0002, 1'b0, 2'd1, 1'b0);
        look(mkpc(16'h0, 4'd2, 6'd5, 6'd0), 2'd1, 1'b0);
        expect_hit("R6 refresh in place", 32'h6000_0002, 1'b0);
        for (int t = 3; t <= 5; t++) begin
            look(mkpc(16'h0, 4'(t), 6'd5, 6'd0), 2'd1, 1'b0);
            expect_hit("R6 refresh kept others", 32'h5000_0000 + 32'(t), t != 5);
        end
        train(mkpc(16'h0, 4'd6, 6'd5, 6'd0), 32'h5000_0006, 1'b1, 2'd1, 1'b0);
        look(mkpc(16'h0, 4'd2, 6'd5, 6'd0), 2'd1, 1'b0);
        expect_miss("R7 refreshed entry still evicted next");
        for (int t = 3; t <= 6; t++) begin
            look(mkpc(16'h0, 4'(t), 6'd5, 6'd0), 2'd1, 1'b0);
            expect_hit("R7 after second eviction", 32'h5000_0000 + 32'(t), t != 5);
        end

        // R5: lookup and update to the same entry in one cycle
        wipe();
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = mkpc(16'h0, 4'd7, 6'd20, 6'd0); lk_priv = 2'd0;
        up_valid = 1'b1; up_pc = mkpc(16'h0, 4'd7, 6'd20, 6'd0); up_target = 32'h7777_0000;
        up_taken = 1'b1; up_priv = 2'd0; up_fault = 1'b0;
        @(negedge clk);
        lk_valid = 1'b0; up_valid = 1'b0;
        r_hit = pr_hit; r_tgt = pr_target; r_taken = pr_taken;
        expect_miss("R5 same-cycle update invisible");
        look(mkpc(16'h0, 4'd7, 6'd20, 6'd0), 2'd0, 1'b0);
        expect_hit("R5 update visible later", 32'h7777_0000, 1'b1);

        // R10: barrier and update together
        @(negedge clk);
        barrier = 1'b1;
        up_valid = 1'b1; up_pc = mkpc(16'h0, 4'd8, 6'd21, 6'd0); up_target = 32'h8888_0000;
        @(negedge clk);
        barrier = 1'b0; up_valid = 1'b0;
        look(mkpc(16'h0, 4'd8, 6'd21, 6'd0), 2'd0, 1'b0);
        expect_miss("R10 update dropped by barrier");
        look(mkpc(16'h0, 4'd7, 6'd20, 6'd0), 2'd0, 1'b0);
        expect_miss("R10 older entry wiped");

        // R11: owner level x requester level x restriction
        for (int tp = 0; tp < 4; tp++) begin
            for (int lp = 0; lp < 4; lp++) begin
                for (int rs = 0; rs < 2; rs++) begin
                    wipe();
                    train(mkpc(16'hBEEF, 4'd3, 6'd40, 6'd0), 32'h9000_0000 + 32'(tp * 16 + lp),
                          1'b1, 2'(tp), 1'b0);
                    look(mkpc(16'hBEEF, 4'd3, 6'd40, 6'd4), 2'(lp), rs[0]);
                    if (rs == 1 && tp < lp) expect_miss("R11 lower owner hidden");
                    else expect_hit("R11 visible", 32'h9000_0000 + 32'(tp * 16 + lp), 1'b1);
                end
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule